// File: doc/BRIEF.md
# Single-Owner Block Directory for Modified/Invalid Caches

This block is the home directory for a one-level system of private caches in which a cache holds a block either modified or not at all. For every block it keeps at most one owning core. It accepts one coherence request at a time on a valid/ready request port: an exclusive request from a core, a writeback from a core, or a read or byte-masked write from a DMA agent. It answers on a valid/ready response port that carries a response kind, a destination agent, the original requester and a data word. It keeps the block data in an internal memory with a fixed, parameterised read latency.

Ownership moves to a new requester in the same cycle that its request is forwarded to the old owner. A writeback that arrives later from the old owner is therefore refused. A DMA access to an owned block first sends an invalidation to the owner. The directory then waits on a separate owner-data input for the dirty word, places it in memory and completes the DMA access against that word. While a memory read, an invalidation or a response is outstanding, new requests are held off. There are no timeouts, and loads are not told apart from stores.

Top module: `mi_dir_ctrl`

## Requirements
- R1: After reset no block has an owner, `req_ready` is 1 and `rsp_valid` is 0. Block i of memory holds 32'h5A000000 + 3*i, truncated or zero-extended to DW.
- R2: An exclusive request (req_kind 0) to an unowned block reads memory and returns a DATA response (rsp_kind 0) to the requester with the memory word. `rsp_valid` first rises after exactly MEM_LAT clock edges following the accepting edge. The requester then becomes the owner.
- R3: An exclusive request to a block owned by another core gives a FWD response (rsp_kind 1) on the edge after acceptance. `rsp_dst` is the old owner and `rsp_req` is the requester. The requester becomes the owner at once.
- R4: A writeback (req_kind 1) from the recorded owner writes its data to memory, answers ACK (rsp_kind 2) and leaves the block unowned.
- R5: A writeback from any core that is not the recorded owner answers NACK (rsp_kind 3). It leaves memory and ownership unchanged.
- R6: A DMA read (req_kind 2) of an unowned block returns a DMA_DATA response (rsp_kind 5) with the memory word, after the same latency as R2.
- R7: A DMA access to an owned block first sends INV (rsp_kind 4) to the owner. When `inv_valid` brings the owner's word, a DMA read returns that word as DMA_DATA on the next edge, the word is written to memory and the block becomes unowned.
- R8: A DMA write (req_kind 3) to an owned block merges the DMA bytes over the owner's returned word: byte k of `req_data` is taken where `req_be[k]` is 1. The result is written to memory, DMA_DONE (rsp_kind 6) follows, and the block becomes unowned.
- R9: A DMA write to an unowned block reads memory with the R2 latency, merges the enabled bytes over that word, writes the result back and answers DMA_DONE.
- R10: `req_ready` is 0 from the accepting edge until the final response of that request has been taken.
- R11: While `rsp_valid` is 1 and `rsp_ready` is 0, the response kind, destination and data stay unchanged on the next cycle.
- R12: An exclusive request from the current owner answers ACK on the edge after acceptance and leaves ownership and memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Directory can take a request |
| req_kind | input | 2 | 0 exclusive, 1 writeback, 2 DMA read, 3 DMA write |
| req_src | input | IDW | Requesting agent ID |
| req_blk | input | BW | Block index |
| req_data | input | DW | Writeback or DMA write data |
| req_be | input | DW/8 | Byte enables for DMA write |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Receiver takes the response |
| rsp_kind | output | 3 | 0 DATA, 1 FWD, 2 ACK, 3 NACK, 4 INV, 5 DMA_DATA, 6 DMA_DONE |
| rsp_dst | output | IDW | Agent the response is for |
| rsp_req | output | IDW | Original requester of the transaction |
| rsp_blk | output | BW | Block index |
| rsp_data | output | DW | Response data word |
| inv_valid | input | 1 | Owner returns its data after an invalidation |
| inv_data | input | DW | Owner's dirty data word |

## Verification
The main target is the ownership race. A core that loses a block through a forward and then writes it back must get a NACK. A design that moved ownership only later, or checked the writeback against the wrong owner, would acknowledge a stale writeback and corrupt memory. That corruption shows up in the data a later exclusive request reads. DMA writes with partial byte masks to owned and unowned blocks show whether the merge uses the owner's returned word, and not stale memory, as its base. Repeated exclusive requests from an owner, random response backpressure and exact memory latency counts expose directories that answer twice, drop a held response or change it while held, or take a new request while one is still outstanding.

// File: rtl/mi_dir_pkg.sv
package mi_dir_pkg;

  typedef enum logic [1:0] {
    RQ_GETX   = 2'd0,
    RQ_WB     = 2'd1,
    RQ_DMA_RD = 2'd2,
    RQ_DMA_WR = 2'd3
  } req_kind_e;

  typedef enum logic [2:0] {
    RS_DATA     = 3'd0,
    RS_FWD      = 3'd1,
    RS_ACK      = 3'd2,
    RS_NACK     = 3'd3,
    RS_INV      = 3'd4,
    RS_DMA_DATA = 3'd5,
    RS_DMA_DONE = 3'd6
  } rsp_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MEMRD,
    ST_RSP,
    ST_INV_TX,
    ST_INV_WAIT
  } dir_state_e;

  // power-on content of a memory block
  function automatic logic [31:0] seed_word(input int unsigned idx);
    return 32'h5A00_0000 + 32'(idx * 3);
  endfunction

endpackage

// File: rtl/mi_dir_mem.sv
module mi_dir_mem #(
  parameter int NBLK    = 16,
  parameter int DW      = 32,
  parameter int MEM_LAT = 3,
  localparam int BW     = $clog2(NBLK),
  localparam int CW     = $clog2(MEM_LAT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_start,
  input  logic [BW-1:0] rd_blk,
  output logic          rd_done,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [BW-1:0] wr_blk,
  input  logic [DW-1:0] wr_data
);

  logic [DW-1:0] store_q [NBLK];
  logic [CW-1:0] lat_cnt;
  logic [BW-1:0] rd_blk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBLK; i++) begin
        store_q[i] <= DW'(mi_dir_pkg::seed_word(i));
      end
    end else if (wr_en) begin
      store_q[wr_blk] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_cnt  <= '0;
      rd_blk_q <= '0;
    end else if (rd_start) begin
      lat_cnt  <= CW'(MEM_LAT);
      rd_blk_q <= rd_blk;
    end else if (lat_cnt != '0) begin
      lat_cnt <= lat_cnt - 1'b1;
    end
  end

  assign rd_done = (lat_cnt == CW'(1));
  assign rd_data = store_q[rd_blk_q];

endmodule

// File: rtl/mi_dir_owner_tbl.sv
module mi_dir_owner_tbl #(
  parameter int NBLK = 16,
  parameter int IDW  = 3,
  localparam int BW  = $clog2(NBLK)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [BW-1:0]  lk_blk,
  output logic           lk_vld,
  output logic [IDW-1:0] lk_id,
  input  logic           set_en,
  input  logic           clr_en,
  input  logic [BW-1:0]  wr_blk,
  input  logic [IDW-1:0] wr_id
);

  logic [NBLK-1:0] own_vld;
  logic [IDW-1:0]  own_id [NBLK];

  for (genvar g = 0; g < NBLK; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        own_vld[g] <= 1'b0;
        own_id[g]  <= '0;
      end else if (wr_blk == BW'(g)) begin
        if (set_en) begin
          own_vld[g] <= 1'b1;
          own_id[g]  <= wr_id;
        end else if (clr_en) begin
          own_vld[g] <= 1'b0;
        end
      end
    end
  end

  assign lk_vld = own_vld[lk_blk];
  assign lk_id  = own_id[lk_blk];

endmodule

// File: rtl/mi_dir_ctrl.sv
module mi_dir_ctrl #(
  parameter int NCORE   = 4,
  parameter int NDMA    = 1,
  parameter int NBLK    = 16,
  parameter int DW      = 32,
  parameter int MEM_LAT = 3,
  localparam int IDW    = $clog2(NCORE + NDMA),
  localparam int BW     = $clog2(NBLK),
  localparam int BEW    = DW / 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [1:0]     req_kind,
  input  logic [IDW-1:0] req_src,
  input  logic [BW-1:0]  req_blk,
  input  logic [DW-1:0]  req_data,
  input  logic [BEW-1:0] req_be,
  output logic           rsp_valid,
  input  logic           rsp_ready,
  output logic [2:0]     rsp_kind,
  output logic [IDW-1:0] rsp_dst,
  output logic [IDW-1:0] rsp_req,
  output logic [BW-1:0]  rsp_blk,
  output logic [DW-1:0]  rsp_data,
  input  logic           inv_valid,
  input  logic [DW-1:0]  inv_data
);
  import mi_dir_pkg::*;

  function automatic logic [DW-1:0] merge_bytes(input logic [DW-1:0] base,
                                                input logic [DW-1:0] upd,
                                                input logic [BEW-1:0] be);
    logic [DW-1:0] r;
    r = base;
    for (int k = 0; k < BEW; k++) begin
      if (be[k]) r[8*k +: 8] = upd[8*k +: 8];
    end
    return r;
  endfunction

  dir_state_e     state, nxt_state;
  req_kind_e      cur_kind, w_kind;
  logic [IDW-1:0] cur_src, w_src;
  logic [BW-1:0]  cur_blk, w_blk;
  logic [DW-1:0]  cur_data, w_data;
  logic [BEW-1:0] cur_be, w_be;

  // named internal events
  logic           accept;
  logic           lk_vld;
  logic [IDW-1:0] lk_id;
  logic           owner_hit;
  logic           mem_rd_start, mem_rd_done;
  logic [DW-1:0]  mem_rd_data;
  logic           mem_wr;
  logic [DW-1:0]  mem_wdata;
  logic           tbl_set, tbl_clr;

  logic           ld_rsp;
  rsp_kind_e      n_kind;
  logic [IDW-1:0] n_dst;
  logic [DW-1:0]  n_data;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  // working request: live port in idle, latched copy otherwise
  always_comb begin
    if (state == ST_IDLE) begin
      w_kind = req_kind_e'(req_kind);
      w_src  = req_src;
      w_blk  = req_blk;
      w_data = req_data;
      w_be   = req_be;
    end else begin
      w_kind = cur_kind;
      w_src  = cur_src;
      w_blk  = cur_blk;
      w_data = cur_data;
      w_be   = cur_be;
    end
  end

  assign owner_hit = lk_vld && (lk_id == w_src);

  mi_dir_owner_tbl #(.NBLK(NBLK), .IDW(IDW)) u_tbl (
    .clk    (clk),
    .rst_n  (rst_n),
    .lk_blk (w_blk),
    .lk_vld (lk_vld),
    .lk_id  (lk_id),
    .set_en (tbl_set),
    .clr_en (tbl_clr),
    .wr_blk (w_blk),
    .wr_id  (w_src)
  );

  mi_dir_mem #(.NBLK(NBLK), .DW(DW), .MEM_LAT(MEM_LAT)) u_mem (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_start (mem_rd_start),
    .rd_blk   (w_blk),
    .rd_done  (mem_rd_done),
    .rd_data  (mem_rd_data),
    .wr_en    (mem_wr),
    .wr_blk   (w_blk),
    .wr_data  (mem_wdata)
  );

  always_comb begin
    nxt_state    = state;
    ld_rsp       = 1'b0;
    n_kind       = RS_ACK;
    n_dst        = w_src;
    n_data       = '0;
    tbl_set      = 1'b0;
    tbl_clr      = 1'b0;
    mem_rd_start = 1'b0;
    mem_wr       = 1'b0;
    mem_wdata    = w_data;
    unique case (state)
      ST_IDLE: begin
        if (req_valid) begin
          unique case (w_kind)
            RQ_GETX: begin
              if (!lk_vld) begin
                mem_rd_start = 1'b1;
              end else if (owner_hit) begin
                ld_rsp = 1'b1;
                n_kind = RS_ACK;
              end else begin
                ld_rsp  = 1'b1;
                n_kind  = RS_FWD;
                n_dst   = lk_id;
                tbl_set = 1'b1;
              end
            end
            RQ_WB: begin
              ld_rsp = 1'b1;
              if (owner_hit) begin
                n_kind  = RS_ACK;
                mem_wr  = 1'b1;
                tbl_clr = 1'b1;
              end else begin
                n_kind = RS_NACK;
              end
            end
            RQ_DMA_RD, RQ_DMA_WR: begin
              if (lk_vld) begin
                ld_rsp = 1'b1;
                n_kind = RS_INV;
                n_dst  = lk_id;
              end else begin
                mem_rd_start = 1'b1;
              end
            end
            default: ;
          endcase
          nxt_state = mem_rd_start ? ST_MEMRD : ST_RSP;
          if (ld_rsp && n_kind == RS_INV) nxt_state = ST_INV_TX;
        end
      end
      ST_MEMRD: begin
        if (mem_rd_done) begin
          ld_rsp    = 1'b1;
          nxt_state = ST_RSP;
          unique case (w_kind)
            RQ_GETX: begin
              n_kind  = RS_DATA;
              n_data  = mem_rd_data;
              tbl_set = 1'b1;
            end
            RQ_DMA_RD: begin
              n_kind = RS_DMA_DATA;
              n_data = mem_rd_data;
            end
            default: begin
              n_kind    = RS_DMA_DONE;
              mem_wr    = 1'b1;
              mem_wdata = merge_bytes(mem_rd_data, w_data, w_be);
            end
          endcase
        end
      end
      ST_INV_WAIT: begin
        if (inv_valid) begin
          ld_rsp    = 1'b1;
          nxt_state = ST_RSP;
          tbl_clr   = 1'b1;
          mem_wr    = 1'b1;
          if (w_kind == RQ_DMA_RD) begin
            n_kind    = RS_DMA_DATA;
            n_data    = inv_data;
            mem_wdata = inv_data;
          end else begin
            n_kind    = RS_DMA_DONE;
            mem_wdata = merge_bytes(inv_data, w_data, w_be);
          end
        end
      end
      ST_INV_TX: begin
        if (rsp_ready) nxt_state = ST_INV_WAIT;
      end
      ST_RSP: begin
        if (rsp_ready) nxt_state = ST_IDLE;
      end
      default: nxt_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_kind  <= RQ_GETX;
      cur_src   <= '0;
      cur_blk   <= '0;
      cur_data  <= '0;
      cur_be    <= '0;
      rsp_valid <= 1'b0;
      rsp_kind  <= '0;
      rsp_dst   <= '0;
      rsp_req   <= '0;
      rsp_blk   <= '0;
      rsp_data  <= '0;
    end else begin
      state <= nxt_state;
      if (accept) begin
        cur_kind <= w_kind;
        cur_src  <= w_src;
        cur_blk  <= w_blk;
        cur_data <= w_data;
        cur_be   <= w_be;
      end
      if (ld_rsp) begin
        rsp_valid <= 1'b1;
        rsp_kind  <= n_kind;
        rsp_dst   <= n_dst;
        rsp_req   <= w_src;
        rsp_blk   <= w_blk;
        rsp_data  <= n_data;
      end else if (rsp_valid && rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/mi_dir_chk.sv
module mi_dir_chk #(
  parameter int IDW = 3,
  parameter int DW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic [1:0]     req_kind,
  input logic [IDW-1:0] req_src,
  input logic           rsp_valid,
  input logic           rsp_ready,
  input logic [2:0]     rsp_kind,
  input logic [IDW-1:0] rsp_dst,
  input logic [DW-1:0]  rsp_data,
  input logic           lk_vld,
  input logic [IDW-1:0] lk_id,
  input logic           mem_rd_done
);

  logic acc;
  assign acc = req_valid && req_ready;

  a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_kind) &&
                                $stable(rsp_dst) && $stable(rsp_data));

  a_r10_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  a_r5_stale_wb_nack: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_kind == 2'd1 && !(lk_vld && lk_id == req_src)
      |=> rsp_valid && rsp_kind == 3'd3);

  a_r3_forward_owner: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_kind == 2'd0 && lk_vld && lk_id != req_src
      |=> rsp_valid && rsp_kind == 3'd1 && rsp_dst == $past(lk_id));

  a_r7_dma_invalidates: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_kind[1] && lk_vld |=> rsp_valid && rsp_kind == 3'd4);

  a_r2_read_yields_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_done |=> rsp_valid);

endmodule

bind mi_dir_ctrl mi_dir_chk #(.IDW(IDW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_kind    (req_kind),
  .req_src     (req_src),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_kind    (rsp_kind),
  .rsp_dst     (rsp_dst),
  .rsp_data    (rsp_data),
  .lk_vld      (lk_vld),
  .lk_id       (lk_id),
  .mem_rd_done (mem_rd_done)
);

// File: tb/sim_mi_dir_ctrl.sv
module sim_mi_dir_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NCORE = 4, NDMA = 1, NBLK = 16, DW = 32, LAT = 3;
  localparam int IDW = $clog2(NCORE + NDMA), BW = $clog2(NBLK), BEW = DW / 8;
  localparam logic [IDW-1:0] DMA_ID = IDW'(NCORE);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, rsp_ready = 0, inv_valid = 0;
  logic [1:0] req_kind = 0;
  logic [IDW-1:0] req_src = 0;
  logic [BW-1:0] req_blk = 0;
  logic [DW-1:0] req_data = 0, inv_data = 0;
  logic [BEW-1:0] req_be = 0;
  logic req_ready, rsp_valid;
  logic [2:0] rsp_kind;
  logic [IDW-1:0] rsp_dst, rsp_req;
  logic [BW-1:0] rsp_blk;
  logic [DW-1:0] rsp_data;

  int errors = 0, checks = 0, cyc = 0;
  bit use_bp = 0;
  logic [DW-1:0] m_mem [NBLK];
  bit m_vld [NBLK];
  logic [IDW-1:0] m_own [NBLK];

  always #(CLK_PERIOD/2) clk = ~clk;

  mi_dir_ctrl #(.NCORE(NCORE), .NDMA(NDMA), .NBLK(NBLK), .DW(DW), .MEM_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_src(req_src), .req_blk(req_blk), .req_data(req_data),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind),
    .rsp_dst(rsp_dst), .rsp_req(rsp_req), .rsp_blk(rsp_blk), .rsp_data(rsp_data),
    .inv_valid(inv_valid), .inv_data(inv_data));

  function automatic logic [DW-1:0] exp_merge(logic [DW-1:0] b, logic [DW-1:0] u, logic [BEW-1:0] e);
    logic [DW-1:0] r = b;
    for (int k = 0; k < BEW; k++) if (e[k]) r[8*k +: 8] = u[8*k +: 8];
    return r;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic send(logic [1:0] k, logic [IDW-1:0] s, logic [BW-1:0] b,
                      logic [DW-1:0] d, logic [BEW-1:0] e);
    @(negedge clk);
    req_kind = k; req_src = s; req_blk = b; req_data = d; req_be = e; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic get_rsp(output logic [2:0] k, output logic [IDW-1:0] dst,
                         output logic [IDW-1:0] rq, output logic [DW-1:0] d, output int n);
    bit seen = 0, busy_ok = 1, hold_ok = 1, rdy;
    n = 0;
    forever begin
      @(negedge clk);
      if (req_ready) busy_ok = 0;
      if (!seen) n++;
      if (rsp_valid) begin
        if (!seen) begin
          seen = 1; k = rsp_kind; dst = rsp_dst; rq = rsp_req; d = rsp_data;
        end else if (rsp_kind != k || rsp_dst != dst || rsp_data != d) hold_ok = 0;
        rdy = use_bp ? 1'($urandom % 2) : 1'b1;
        rsp_ready = rdy;
        if (rdy) begin
          @(posedge clk); #1;
          rsp_ready = 0;
          break;
        end
      end
    end
    chk(busy_ok, "R10 req_ready low while busy", 0, 0);
    chk(hold_ok, "R11 response stable under backpressure", 0, 0);
  endtask

  task automatic give_inv(logic [DW-1:0] d);
    @(negedge clk);
    inv_valid = 1; inv_data = d;
    @(posedge clk); #1;
    inv_valid = 0;
  endtask

  // one full transaction, checked against the bench model
  task automatic txn(logic [1:0] k, logic [IDW-1:0] s, logic [BW-1:0] b,
                     logic [DW-1:0] d, logic [BEW-1:0] e, logic [DW-1:0] own_d);
    logic [2:0] rk; logic [IDW-1:0] rd, rq; logic [DW-1:0] rdat; int n;
    send(k, s, b, d, e);
    get_rsp(rk, rd, rq, rdat, n);
    case (k)
      2'd0: begin
        if (!m_vld[b]) begin
          chk(rk == 0 && rd == s, "R2 DATA kind/dst", {rk, rd}, {3'd0, s});
          chk(rdat == m_mem[b], "R2 DATA word", rdat, m_mem[b]);
          chk(n == LAT + 1, "R2 read latency", n, LAT + 1);
          m_vld[b] = 1; m_own[b] = s;
        end else if (m_own[b] == s) begin
          chk(rk == 2 && rd == s && n == 1, "R12 owner re-request ACK", {rk, rd}, {3'd2, s});
        end else begin
          chk(rk == 1 && rd == m_own[b] && rq == s && n == 1, "R3 forward to owner",
              {rk, rd, rq}, {3'd1, m_own[b], s});
          m_own[b] = s;
        end
      end
      2'd1: begin
        if (m_vld[b] && m_own[b] == s) begin
          chk(rk == 2 && rd == s, "R4 writeback ACK", {rk, rd}, {3'd2, s});
          m_mem[b] = d; m_vld[b] = 0;
        end else begin
          chk(rk == 3 && rd == s, "R5 stale writeback NACK", {rk, rd}, {3'd3, s});
        end
      end
      default: begin
        if (m_vld[b]) begin
          chk(rk == 4 && rd == m_own[b], "R7 INV to owner", {rk, rd}, {3'd4, m_own[b]});
          give_inv(own_d);
          get_rsp(rk, rd, rq, rdat, n);
          if (k == 2'd2) begin
            chk(rk == 5 && rdat == own_d && n == 1, "R7 DMA read gets owner word", rdat, own_d);
            m_mem[b] = own_d;
          end else begin
            chk(rk == 6 && rd == s && n == 1, "R8 DMA write done", rk, 6);
            m_mem[b] = exp_merge(own_d, d, e);
          end
          m_vld[b] = 0;
        end else if (k == 2'd2) begin
          chk(rk == 5 && rd == s && rdat == m_mem[b], "R6 DMA read word", rdat, m_mem[b]);
          chk(n == LAT + 1, "R6 read latency", n, LAT + 1);
        end else begin
          chk(rk == 6 && rd == s && n == LAT + 1, "R9 DMA write done", {rk, 8'(n)}, {3'd6, 8'(LAT + 1)});
          m_mem[b] = exp_merge(m_mem[b], d, e);
        end
      end
    endcase
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NBLK; i++) begin
      m_mem[i] = 32'h5A00_0000 + 32'(i * 3); m_vld[i] = 0; m_own[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(req_ready === 1'b1 && rsp_valid === 1'b0, "R1 reset state", {req_ready, rsp_valid}, 2'b10);
    // directed: ownership race
    txn(0, 1, 0, 0, 0, 0);                 // R2
    txn(0, 2, 0, 0, 0, 0);                 // R3
    txn(1, 1, 0, 32'hDEAD_0001, 0, 0);     // R5 loser writes back
    txn(1, 2, 0, 32'hCAFE_0002, 0, 0);     // R4
    txn(0, 3, 0, 0, 0, 0);                 // R2/R4: reads written-back data
    txn(0, 3, 0, 0, 0, 0);                 // R12
    txn(2, DMA_ID, 0, 0, 0, 32'h1234_5678); // R7
    txn(0, 3, 0, 0, 0, 0);                 // R7: memory now holds owner word
    txn(3, DMA_ID, 0, 32'hAABB_CCDD, 4'b0101, 32'h1111_2222); // R8
    txn(3, DMA_ID, 5, 32'h9988_7766, 4'b1010, 0);             // R9
    txn(2, DMA_ID, 5, 0, 0, 0);            // R6/R9 merged word
    txn(1, 0, 7, 32'h0, 0, 0);             // R5 unowned block
    txn(0, 0, 7, 0, 0, 0);                 // R5: memory unchanged
    // random phase with backpressure
    use_bp = 1;
    for (int t = 0; t < 600; t++) begin
      logic [1:0] k = 2'($urandom % 4);
      logic [IDW-1:0] s = k[1] ? DMA_ID : IDW'($urandom % NCORE);
      txn(k, s, BW'($urandom % 4), $urandom, BEW'($urandom), $urandom);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule